// File: doc/BRIEF.md
# TLB Invalidation Sweep Engine

This engine removes translations from a two-part TLB by walking its entries one per cycle and clearing the exist bit of every entry that satisfies the rule a command selects. The TLB has a set-associative region of `WAYS` ways by `SETS` sets, where all entries share one page size supplied on `sa_ps`. It also has a fully associative region of `FA_N` entries, and each of those carries its own page size. Entry indices run from 0 to `WAYS*SETS-1` for the set-associative region, way-major, so way `w` of set `s` is index `w*SETS+s`. The fully associative entries follow after them.

A command is a request on a valid/ready pair. `cmd_ready` is high whenever no sweep is running. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the engine is busy it holds `cmd_ready` low, and a caller must hold `cmd_valid` and its fields until acceptance. During a sweep the engine presents an entry index on `ent_idx`. The storage returns that entry's fields in the same cycle. When the entry is to be removed, `clr_en` tells the storage to clear its exist bit at the next edge. When the walk ends, `done` and `xlat_flush` pulse together so that any downstream translation cache can drop its contents.

Top module: `tlb_inv_sweep`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy`, `done`, `xlat_flush` and `clr_en` are 0 and `cmd_ready` is 1.
- R2: An accepted command with a non-empty scope raises `busy` at the accepting edge. `busy` stays high for exactly one cycle per entry in scope, and `ent_idx` moves to the next entry in scope every cycle. `cmd_ready` is 0 throughout the sweep.
- R3: `done` and `xlat_flush` are high for exactly one cycle. That cycle is the one after the last sweep cycle, or the one after acceptance when the scope is empty.
- R4: Op code 0 clears every existing entry in the whole TLB.
- R5: Op code 1 sweeps the whole TLB and clears entries whose global bit equals `cmd_g`.
- R6: Op code 2 sweeps the whole TLB and clears non-global entries whose ASID equals `cmd_asid`.
- R7: Op code 3 clears non-global entries whose ASID equals `cmd_asid` and whose page matches. An entry's page matches when `cmd_va >> (ps+1)` equals `{ent_vppn, VPPN_LSB zero bits} >> (ps+1)`, where `ps` is that entry's page size.
- R8: Op code 4 clears entries that match the page and are either global or have an ASID equal to `cmd_asid`.
- R9: For set-associative entries, the page size used is the `sa_ps` value captured when the command is accepted. Later changes to `sa_ps` do not affect that sweep. Fully associative entries use their own `ent_ps`.
- R10: Op codes 5 and 6 have a scope set by `cmd_idx`. An index below `WAYS*SETS` selects the `WAYS` entries of set `cmd_idx mod SETS`, visited in way order 0 upward. An index from `WAYS*SETS` to `WAYS*SETS+FA_N-1` selects all fully associative entries. A larger index selects nothing.
- R11: Within that scope, op code 5 clears only non-global entries whose ASID equals `cmd_asid`, and op code 6 clears every entry.
- R12: `clr_en` is asserted only for an entry whose exist bit is 1.
- R13: Op code 7 sweeps the whole TLB and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 3 | Operation code (0..7, see R4 to R13) |
| cmd_asid | input | ASID_W | ASID compared by the ASID-based rules |
| cmd_g | input | 1 | Global-bit value for op code 1 |
| cmd_va | input | VA_W | Virtual address for the page-based rules |
| cmd_idx | input | IDX_W | Index that selects the scope of op codes 5 and 6 |
| sa_ps | input | PS_W | Shared page size of the set-associative region |
| ent_idx | output | IDX_W | Entry currently visited |
| ent_e | input | 1 | Exist bit of the visited entry |
| ent_g | input | 1 | Global bit of the visited entry |
| ent_asid | input | ASID_W | ASID of the visited entry |
| ent_ps | input | PS_W | Page size of the visited entry (used for the fully associative region only) |
| ent_vppn | input | VA_W-VPPN_LSB | Virtual double-page number of the visited entry |
| clr_en | output | 1 | Clear the exist bit of `ent_idx` at this edge |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| xlat_flush | output | 1 | One-cycle flush request to downstream translation caches |

## Verification
The assertions assume that the storage returns the fields of `ent_idx` combinationally in the same cycle. They also assume that no other agent changes an entry while a sweep is running, so the only exist-bit changes come from `clr_en`. The page rule further assumes that each page size is at least `VPPN_LSB-1`. The stimulus respects all of these assumptions. The bench's storage model answers reads combinationally, it is written only at `clr_en` edges, and it is refilled only between commands. The model uses page sizes of 12 and up with `VPPN_LSB` at 13. `cmd_valid` and the command fields are held until the accepting edge. `sa_ps` is deliberately changed once a command has been accepted, which exercises only the capture behaviour.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [2:0] {
    OP_ALL      = 3'd0,
    OP_GSEL     = 3'd1,
    OP_ASID     = 3'd2,
    OP_PG_ASID  = 3'd3,
    OP_PG_AORG  = 3'd4,
    OP_LN_CLR   = 3'd5,
    OP_LN_FLUSH = 3'd6,
    OP_NONE     = 3'd7
  } inv_op_e;

  function automatic logic is_line_op(inv_op_e op);
    return (op == OP_LN_CLR) || (op == OP_LN_FLUSH);
  endfunction

endpackage

// File: rtl/tlbinv_walk.sv
// Scope decoder and entry sequencer: one entry index per cycle.
module tlbinv_walk #(
  parameter int WAYS  = 8,
  parameter int SETS  = 256,
  parameter int FA_N  = 64,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             line_op,
  input  logic [IDX_W-1:0] req_idx,
  output logic             empty,
  output logic             active,
  output logic [IDX_W-1:0] cur_idx,
  output logic             last
);
  localparam int SA_N  = WAYS * SETS;
  localparam int TOTAL = SA_N + FA_N;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [31:0]      ri;
  logic [CNT_W-1:0] len_d, len_q, cnt;
  logic [IDX_W-1:0] base_d, base_q;
  logic             strided_d, strided_q;

  assign ri = 32'(req_idx);

  // Scope: whole array, one set line across the ways, the fully
  // associative region, or nothing for an out-of-range index.
  always_comb begin
    len_d     = CNT_W'(TOTAL);
    base_d    = '0;
    strided_d = 1'b0;
    if (line_op) begin
      if (ri < 32'(SA_N)) begin
        len_d     = CNT_W'(WAYS);
        base_d    = IDX_W'(ri % 32'(SETS));
        strided_d = 1'b1;
      end else if (ri < 32'(TOTAL)) begin
        len_d  = CNT_W'(FA_N);
        base_d = IDX_W'(SA_N);
      end else begin
        len_d = '0;
      end
    end
  end

  assign empty = (len_d == '0);
  assign last  = (cnt == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      len_q     <= '0;
      base_q    <= '0;
      strided_q <= 1'b0;
    end else if (start && !empty) begin
      active    <= 1'b1;
      cnt       <= '0;
      len_q     <= len_d;
      base_q    <= base_d;
      strided_q <= strided_d;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end

  assign cur_idx = strided_q ? IDX_W'(32'(base_q) + 32'(cnt) * 32'(SETS))
                             : IDX_W'(32'(base_q) + 32'(cnt));
endmodule

// File: rtl/tlbinv_match.sv
// Per-entry removal rule for the operation in progress.
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int ASID_W   = 10,
  parameter int PS_W     = 6,
  parameter int VA_W     = 48,
  parameter int VPPN_LSB = 13
) (
  input  inv_op_e                 op,
  input  logic [ASID_W-1:0]       asid,
  input  logic                    g_sel,
  input  logic [VA_W-1:0]         va,
  input  logic [PS_W-1:0]         ps,
  input  logic                    ent_g,
  input  logic [ASID_W-1:0]       ent_asid,
  input  logic [VA_W-VPPN_LSB-1:0] ent_vppn,
  output logic                    hit
);
  logic [VA_W-1:0] ent_va, keep_mask;
  logic [PS_W:0]   shamt;
  logic            page_ok, asid_ok;

  assign ent_va    = {ent_vppn, {VPPN_LSB{1'b0}}};
  assign shamt     = {1'b0, ps} + 1'b1;
  assign keep_mask = {VA_W{1'b1}} << shamt;
  assign page_ok   = ((va ^ ent_va) & keep_mask) == '0;
  assign asid_ok   = (ent_asid == asid);

  always_comb begin
    unique case (op)
      OP_ALL:      hit = 1'b1;
      OP_GSEL:     hit = (ent_g == g_sel);
      OP_ASID:     hit = !ent_g && asid_ok;
      OP_PG_ASID:  hit = !ent_g && asid_ok && page_ok;
      OP_PG_AORG:  hit = (ent_g || asid_ok) && page_ok;
      OP_LN_CLR:   hit = !ent_g && asid_ok;
      OP_LN_FLUSH: hit = 1'b1;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_inv_sweep.sv
module tlb_inv_sweep
  import tlbinv_pkg::*;
#(
  parameter int WAYS     = 8,
  parameter int SETS     = 256,
  parameter int FA_N     = 64,
  parameter int ASID_W   = 10,
  parameter int PS_W     = 6,
  parameter int VA_W     = 48,
  parameter int VPPN_LSB = 13,
  localparam int SA_N    = WAYS * SETS,
  localparam int TOTAL   = SA_N + FA_N,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int VPPN_W  = VA_W - VPPN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_g,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [PS_W-1:0]   sa_ps,
  output logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_e,
  input  logic              ent_g,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [PS_W-1:0]   ent_ps,
  input  logic [VPPN_W-1:0] ent_vppn,
  output logic              clr_en,
  output logic              busy,
  output logic              done,
  output logic              xlat_flush
);
  inv_op_e           op_q;
  logic [ASID_W-1:0] asid_q;
  logic              g_q;
  logic [VA_W-1:0]   va_q;
  logic [PS_W-1:0]   sa_ps_q, ps_sel;
  logic              accept, empty, last, hit, done_q;
  logic [IDX_W-1:0]  cur_idx;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      asid_q  <= '0;
      g_q     <= 1'b0;
      va_q    <= '0;
      sa_ps_q <= '0;
    end else if (accept) begin
      op_q    <= inv_op_e'(cmd_op);
      asid_q  <= cmd_asid;
      g_q     <= cmd_g;
      va_q    <= cmd_va;
      sa_ps_q <= sa_ps;
    end
  end

  tlbinv_walk #(
    .WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .IDX_W(IDX_W)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .line_op (is_line_op(inv_op_e'(cmd_op))),
    .req_idx (cmd_idx),
    .empty   (empty),
    .active  (busy),
    .cur_idx (cur_idx),
    .last    (last)
  );

  assign ps_sel = (32'(cur_idx) < 32'(SA_N)) ? sa_ps_q : ent_ps;

  tlbinv_match #(
    .ASID_W(ASID_W), .PS_W(PS_W), .VA_W(VA_W), .VPPN_LSB(VPPN_LSB)
  ) u_match (
    .op       (op_q),
    .asid     (asid_q),
    .g_sel    (g_q),
    .va       (va_q),
    .ps       (ps_sel),
    .ent_g    (ent_g),
    .ent_asid (ent_asid),
    .ent_vppn (ent_vppn),
    .hit      (hit)
  );

  assign ent_idx = cur_idx;
  assign clr_en  = busy && ent_e && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (busy && last) || (accept && empty);
  end

  assign done       = done_q;
  assign xlat_flush = done_q;
endmodule

// File: rtl/tlb_inv_sweep_chk.sv
module tlb_inv_sweep_chk #(
  parameter int ASID_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              clr_en,
  input logic              ent_e,
  input logic              ent_g,
  input logic [ASID_W-1:0] ent_asid,
  input logic [2:0]        op_q,
  input logic [ASID_W-1:0] asid_q,
  input logic              g_q
);
  // R12: only live entries are cleared
  a_r12_clear_live: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> ent_e);

  // R2: clears happen only inside a sweep
  a_r2_clear_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> busy);

  // R3: completion is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: every sweep ends with the completion pulse
  a_r3_end_signalled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5: global-select clears only entries with the chosen global bit
  a_r5_gsel_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && op_q == 3'd1) |-> (ent_g == g_q));

  // R6: ASID op never removes a global entry or a foreign ASID
  a_r6_asid_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && op_q == 3'd2) |-> (!ent_g && ent_asid == asid_q));

  // R13: op code 7 clears nothing
  a_r13_none_rule: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (op_q != 3'd7));
endmodule

bind tlb_inv_sweep tlb_inv_sweep_chk #(.ASID_W(ASID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .clr_en   (clr_en),
  .ent_e    (ent_e),
  .ent_g    (ent_g),
  .ent_asid (ent_asid),
  .op_q     (op_q),
  .asid_q   (asid_q),
  .g_q      (g_q)
);

// File: tb/sim_tlb_inv_sweep.sv
module sim_tlb_inv_sweep;
  localparam int WAYS = 8, SETS = 256, FA_N = 64;
  localparam int ASID_W = 10, PS_W = 6, VA_W = 48, VPPN_LSB = 13;
  localparam int SA_N = WAYS * SETS, TOTAL = SA_N + FA_N;
  localparam int IDX_W = $clog2(TOTAL), VPPN_W = VA_W - VPPN_LSB;
  localparam logic [VA_W-1:0] VA0 = 48'h00AB_CDE0_1F7C;

  localparam int NV = 14;
  localparam int V_OP  [NV] = '{0, 1, 1, 2, 3, 3, 4, 5, 5, 6, 6, 6, 7, 5};
  localparam int V_ASID[NV] = '{0, 0, 0, 2, 1, 3, 2, 1, 2, 0, 0, 0, 1, 1};
  localparam int V_G   [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_IDX [NV] = '{0, 0, 0, 0, 0, 0, 0, 37, SA_N+5, 456,
                                SA_N+63, 4000, 0, 4095};
  localparam int V_PS  [NV] = '{12, 12, 12, 12, 12, 14, 13, 12, 12, 12,
                                12, 12, 12, 21};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, cmd_valid, cmd_ready, cmd_g;
  logic [2:0]        cmd_op;
  logic [ASID_W-1:0] cmd_asid;
  logic [VA_W-1:0]   cmd_va;
  logic [IDX_W-1:0]  cmd_idx, ent_idx;
  logic [PS_W-1:0]   sa_ps;
  logic              ent_e, ent_g, clr_en, busy, done, xlat_flush;
  logic [ASID_W-1:0] ent_asid;
  logic [PS_W-1:0]   ent_ps;
  logic [VPPN_W-1:0] ent_vppn;

  logic              m_e    [TOTAL];
  logic              m_g    [TOTAL];
  logic [ASID_W-1:0] m_asid [TOTAL];
  logic [PS_W-1:0]   m_ps   [TOTAL];
  logic [VPPN_W-1:0] m_vppn [TOTAL];
  logic              exp_e  [TOTAL];
  int checks = 0, errors = 0, bad_wr = 0;
  bit finished = 0;

  tlb_inv_sweep u0 (.*);

  assign ent_e    = m_e[ent_idx];
  assign ent_g    = m_g[ent_idx];
  assign ent_asid = m_asid[ent_idx];
  assign ent_ps   = m_ps[ent_idx];
  assign ent_vppn = m_vppn[ent_idx];

  always @(posedge clk) begin
    if (clr_en) begin
      if (!m_e[ent_idx]) bad_wr <= bad_wr + 1;
      m_e[ent_idx] <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < TOTAL; i++) begin
      m_e[i]    = (i % 7) != 3;
      m_g[i]    = (i % 5) == 0;
      m_asid[i] = ASID_W'(i % 4);
      m_ps[i]   = (i < SA_N) ? '0 :
                  ((i % 4 == 0) ? 6'd12 : (i % 4 == 1) ? 6'd13 :
                   (i % 4 == 2) ? 6'd14 : 6'd21);
      m_vppn[i] = (i % 3 == 0) ? (VA0[VA_W-1:VPPN_LSB] ^ VPPN_W'((i >> 2) & 1))
                               : VPPN_W'(i);
    end
  endtask

  function automatic bit page_eq(int i, int sps);
    int ps = (i < SA_N) ? sps : int'(m_ps[i]);
    logic [VA_W-1:0] ev = {m_vppn[i], {VPPN_LSB{1'b0}}};
    return (VA0 >> (ps + 1)) == (ev >> (ps + 1));
  endfunction

  function automatic bit removes(int i, int op, int asid, int g, int idx, int sps);
    bit in_scope = 1, rule = 0;
    bit aeq = (int'(m_asid[i]) == asid);
    if (op == 5 || op == 6) begin
      if (idx < SA_N)       in_scope = (i < SA_N) && (i % SETS == idx % SETS);
      else if (idx < TOTAL) in_scope = (i >= SA_N);
      else                  in_scope = 0;
    end
    case (op)
      0: rule = 1;
      1: rule = (int'(m_g[i]) == g);
      2: rule = !m_g[i] && aeq;
      3: rule = !m_g[i] && aeq && page_eq(i, sps);
      4: rule = (m_g[i] || aeq) && page_eq(i, sps);
      5: rule = !m_g[i] && aeq;
      6: rule = 1;
      default: rule = 0;
    endcase
    return in_scope && rule;
  endfunction

  function automatic string map_tag(int op);
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7 R9";
      4: return "R8 R9";
      5, 6: return "R10 R11";
      default: return "R13";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_asid = '0; cmd_g = 1'b0;
    cmd_va = '0; cmd_idx = '0; sa_ps = 6'd12;
    fill();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !xlat_flush && !clr_en, "R1", "outputs idle in reset",
        {busy, done, xlat_flush, clr_en}, 0);
    chk(cmd_ready, "R1", "ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && cmd_ready, "R1", "idle after reset",
        {busy, done, cmd_ready}, 1);

    for (int v = 0; v < NV; v++) begin
      int exp_len, cyc, rdy_bad, mism, wr0;
      fill();
      for (int i = 0; i < TOTAL; i++)
        exp_e[i] = m_e[i] && !removes(i, V_OP[v], V_ASID[v], V_G[v], V_IDX[v], V_PS[v]);
      if (V_OP[v] == 5 || V_OP[v] == 6)
        exp_len = (V_IDX[v] < SA_N) ? WAYS : (V_IDX[v] < TOTAL) ? FA_N : 0;
      else
        exp_len = TOTAL;
      wr0 = bad_wr;
      @(negedge clk);
      cmd_op = 3'(V_OP[v]); cmd_asid = ASID_W'(V_ASID[v]); cmd_g = V_G[v] != 0;
      cmd_va = VA0; cmd_idx = IDX_W'(V_IDX[v]); sa_ps = PS_W'(V_PS[v]);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      sa_ps = 6'd40;  // R9: changed after acceptance, must not matter
      cyc = 0; rdy_bad = 0;
      while (busy && cyc < 5000) begin
        if (cmd_ready) rdy_bad++;
        cyc++;
        @(negedge clk);
      end
      chk(cyc == exp_len, "R2 R10", $sformatf("vector %0d sweep length", v), cyc, exp_len);
      chk(rdy_bad == 0, "R2", $sformatf("vector %0d ready during sweep", v), rdy_bad, 0);
      chk(done && xlat_flush, "R3", $sformatf("vector %0d completion pulse", v),
          {done, xlat_flush}, 3);
      @(negedge clk);
      chk(!done && !xlat_flush, "R3", $sformatf("vector %0d pulse width", v),
          {done, xlat_flush}, 0);
      mism = 0;
      for (int i = 0; i < TOTAL; i++) if (m_e[i] !== exp_e[i]) mism++;
      chk(mism == 0, map_tag(V_OP[v]), $sformatf("vector %0d mismatched entries", v),
          mism, 0);
      chk(bad_wr == wr0, "R12", $sformatf("vector %0d clears of dead entries", v),
          bad_wr - wr0, 0);
    end

    // R1: reset in mid-sweep returns to idle
    fill();
    @(negedge clk);
    cmd_op = 3'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !clr_en && !done && cmd_ready, "R1", "idle after mid-sweep reset",
        {busy, clr_en, done, cmd_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "stays idle after release", {busy, done}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule